// File: doc/BRIEF.md
# Parity-Checked Adder with Predicted Result Parity

This block adds two operands that each travel with an even-parity bit, together with a carry-in. It produces the sum, a parity bit for that sum, and an error flag. The result parity is not taken from the sum. It is predicted from the operand parity bits and the carries into every bit position. Those carries come from a second carry chain that is built separately from the one the adder uses.

The error flag is raised when the parity of the actual sum disagrees with the prediction. It is also raised when either incoming operand does not match its own parity bit. Because the output parity is the predicted value, a fault in the sum bits travels on as a parity violation that later stages can detect. A bad operand parity bit travels on in the same way.

The block is purely combinational and its width is a parameter.

Top module: `par_pred_add`

## Requirements
- R1: `sum` equals the low W bits of `a_data + b_data + cin`.
- R2: `sum_par` equals `a_par ^ b_par ^ c0 ^ c1 ^ ... ^ c(W-1)`. Here `c0` is `cin` and `ci` is the carry into bit i. This holds whether or not the incoming parity bits are correct.
- R3: When both operand parity bits are correct, `sum_par` equals the XOR of all bits of `sum`. Parity is even: the parity bit is the XOR of the data bits.
- R4: When both operand parity bits are correct, `fault` is 0.
- R5: When `a_par` differs from the XOR of `a_data`, `fault` is 1.
- R6: When `b_par` differs from the XOR of `b_data`, `fault` is 1.
- R7: With W=8, take `a_data`=8'hB1 with `a_par`=0, `b_data`=8'h3B with `b_par`=1, and `cin`=0. The result is `sum`=8'hEC, `sum_par`=1 and `fault`=0.
- R8: There is no storage. Outputs follow the inputs within the same cycle, including all-zero inputs and the wrap of all-ones plus one to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_data | input | W | First operand |
| a_par | input | 1 | Even parity bit of a_data |
| b_data | input | W | Second operand |
| b_par | input | 1 | Even parity bit of b_data |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum, low W bits |
| sum_par | output | 1 | Predicted parity of sum |
| fault | output | 1 | Prediction mismatch or bad operand parity |

## Verification
The assertions check four things whenever the inputs are stable: the sum value, the agreement between predicted and actual parity on clean operands, the quiet flag on clean operands, and the flag for each corrupted operand parity bit.

The exact predicted formula needs an independent carry model, so only the bench scenarios show it. The same is true of the propagation of a bad input parity into `sum_par`, the worked example, and the wrap cases. The bench checks these against carries it computes bit by bit.

// File: rtl/par_pred_add.sv
module par_pred_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_data,
  input  logic         a_par,
  input  logic [W-1:0] b_data,
  input  logic         b_par,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         sum_par,
  output logic         fault
);

  logic [W-1:0] mc;
  logic [W-1:0] dc;
  logic [W-1:0] gen_v;
  logic [W-1:0] prop_v;
  logic         pred;
  logic         act_par;
  logic         a_bad;
  logic         b_bad;

  assign mc[0] = cin;
  assign dc[0] = cin;
  assign gen_v  = a_data & b_data;
  assign prop_v = a_data | b_data;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign sum[i] = a_data[i] ^ b_data[i] ^ mc[i];
      if (i < W - 1) begin : g_carry
        assign mc[i+1] = (a_data[i] & b_data[i]) | (mc[i] & (a_data[i] ^ b_data[i]));
        assign dc[i+1] = gen_v[i] | (prop_v[i] & dc[i]);
      end
    end
  endgenerate

  assign pred    = a_par ^ b_par ^ (^dc);
  assign act_par = ^sum;
  assign a_bad   = (^a_data) ^ a_par;
  assign b_bad   = (^b_data) ^ b_par;

  assign sum_par = pred;
  assign fault   = (act_par ^ pred) | a_bad | b_bad;

endmodule

// File: rtl/par_pred_add_chk.sv
module par_pred_add_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_data,
  input logic         a_par,
  input logic [W-1:0] b_data,
  input logic         b_par,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         sum_par,
  input logic         fault
);

  logic [W:0] full;
  logic       clean;
  logic       known;

  assign full  = {1'b0, a_data} + {1'b0, b_data} + {{W{1'b0}}, cin};
  assign clean = ((^a_data) == a_par) && ((^b_data) == b_par);
  assign known = !$isunknown({a_data, a_par, b_data, b_par, cin, sum, sum_par, fault});

  always_comb begin
    if (known) begin
      // R1
      sum_value_chk: assert (sum == full[W-1:0]);
      // R3
      par_agree_chk: assert (!clean || (sum_par == ^sum));
      // R4
      quiet_flag_chk: assert (!clean || !fault);
      // R5
      bad_a_flag_chk: assert (((^a_data) == a_par) || fault);
      // R6
      bad_b_flag_chk: assert (((^b_data) == b_par) || fault);
    end
  end

endmodule

bind par_pred_add par_pred_add_chk #(.W(W)) u_chk (.*);

// File: tb/par_pred_add_tb.sv
module par_pred_add_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_data, b_data, sum;
  logic a_par, b_par, cin, sum_par, fault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W+2:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  par_pred_add #(.W(W)) u_dut (
    .a_data(a_data), .a_par(a_par), .b_data(b_data), .b_par(b_par),
    .cin(cin), .sum(sum), .sum_par(sum_par), .fault(fault)
  );

  function automatic logic [W+2:0] model(logic [W-1:0] a, logic ap,
                                         logic [W-1:0] b, logic bp, logic ci);
    logic c;
    logic cx;
    logic [W:0] tot;
    logic ok;
    c = ci;
    cx = 1'b0;
    for (int k = 0; k < W; k++) begin
      cx = cx ^ c;
      c = (a[k] + b[k] + c) > 1;
    end
    tot = a + b + ci;
    ok = ((^a) == ap) && ((^b) == bp);
    return {ok, !ok, ap ^ bp ^ cx, tot[W-1:0]};
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic ap,
                       input logic [W-1:0] b, input logic bp,
                       input logic ci, input string tag);
    @(posedge clk);
    a_data = a; a_par = ap; b_data = b; b_par = bp; cin = ci;
    exp_q.push_back(model(a, ap, b, bp, ci));
    tag_q.push_back(tag);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] want);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, want);
    end
  endtask

  // Monitor: the block is combinational, so results are read in the cycle they were driven (R8)
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W+2:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(sum == e[W-1:0], {t, "/R1"}, "sum", sum, e[W-1:0]);
      check(sum_par == e[W], {t, "/R2"}, "sum_par", {{(W-1){1'b0}}, sum_par}, {{(W-1){1'b0}}, e[W]});
      if (e[W+2]) begin
        check(fault == 1'b0, {t, "/R4"}, "fault", {{(W-1){1'b0}}, fault}, '0);
        check(sum_par == ^sum, {t, "/R3"}, "par_vs_sum", {{(W-1){1'b0}}, sum_par}, {{(W-1){1'b0}}, ^sum});
      end else begin
        check(fault == 1'b1, {t, "/R5_R6"}, "fault", {{(W-1){1'b0}}, fault}, 1);
      end
    end
  end

  initial begin
    logic [31:0] s;
    a_data = '0; b_data = '0; a_par = 0; b_par = 0; cin = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive('0, 0, '0, 0, 0, "R8");
    drive(8'hB1, 0, 8'h3B, 1, 0, "R7");
    drive(8'hFF, 0, 8'h01, 1, 0, "R8");
    drive(8'hFF, 0, 8'h00, 0, 1, "R8");
    drive(8'hFF, 0, 8'hFF, 0, 1, "R1");
    drive(8'hB1, 1, 8'h3B, 1, 0, "R5");
    drive(8'hB1, 0, 8'h3B, 0, 1, "R6");
    drive(8'h55, 1, 8'hAA, 1, 1, "R2");
    drive(8'h80, 1, 8'h80, 1, 0, "R1");
    s = 32'h1234_5678;
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] ra, rb;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      ra = s[W-1:0];
      rb = s[W+7:8];
      drive(ra, (^ra) ^ (n % 7 == 3), rb, (^rb) ^ (n % 11 == 5), s[20],
            (n % 7 == 3) ? "R5" : (n % 11 == 5) ? "R6" : "R3");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule